// File: doc/BRIEF.md
# Dynamic Link Width Controller

This block changes how many lanes of a multi-lane serial link carry traffic, while the link stays up and data keeps moving. A power-management agent asks for a new width. The controller checks the request and takes one transition at a time. For each transition it tells the per-lane transmit logic which lanes must send an electrical-idle ordered set, and which lanes must run a wake handshake. It also publishes the resulting active-lane mask. The same mask drives both directions, so transmit and receive always use one lane count.

A shrink is never applied on the cycle it is requested. It waits for the next periodic skip ordered-set boundary, which arrives as a one-cycle strobe. On the cycle after that strobe, the lanes being removed get a one-cycle electrical-idle ordered-set marker. One cycle later they leave the active set. A grow has two conditions. First, the idle lanes must have served a minimum residency since the last shrink. Second, the partner must acknowledge the wake handshake. Only then are the woken lanes merged in. Lane 0 always stays active, so traffic continues throughout.

This is a control block: requests, strobes and acknowledgements are plain single-cycle or level pins. No data passes through it, so there is no back-pressure.

Top module: `link_width_ctrl`

## Requirements
- R1: After reset the link runs at full width. With the default 16 lanes this means `width` = 16 and `active_mask` = 16'hFFFF. Reset also clears `eios_mask`, `wake_mask`, `busy` and `done`.
- R2: Only the widths 1, 2, 4, 8 and 16 are accepted. A request for any other value (0 to 31) is dropped. The width and mask stay unchanged and `busy` stays low.
- R3: While `flit_mode` is low, a request is dropped even if its width is legal. The width stays unchanged.
- R4: `active_mask` always has its low `width` bits set and all other bits clear. The lanes are contiguous from lane 0, and one mask serves both directions.
- R5: `active_mask` is never zero.
- R6: A legal request for a smaller width leaves `active_mask` unchanged until `skp_boundary` is seen. Until then `eios_mask` stays zero.
- R7: In the cycle after `skp_boundary` is sampled during a pending shrink, `eios_mask` equals exactly the lanes being removed, for one cycle only. In the following cycle those lanes are cleared from `active_mask`.
- R8: A legal request for a larger width drives `wake_mask` with exactly the lanes to be added. `wake_mask` is held while `wake_ack` is low. The cycle after `wake_ack` is sampled, those lanes join `active_mask` and `wake_mask` clears.
- R9: `wake_mask` does not rise until at least RESIDENCY cycles have passed since the last shrink was committed.
- R10: Only one transition runs at a time. A legal request that arrives mid-transition is held and carried out once the current transition commits. If several such requests arrive, the newest one wins.
- R11: `done` is a one-cycle pulse in the cycle the new mask appears. `busy` is high from the cycle after a legal request is captured until that commit.
- R12: A legal request equal to the current width causes no transition. It produces no `done`, and `busy` drops again within two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flit_mode | input | 1 | High when the link runs in flit mode; requests are accepted only then |
| req_valid | input | 1 | One-cycle strobe carrying a width request |
| req_width | input | 5 | Requested lane count |
| skp_boundary | input | 1 | Strobe marking a skip ordered-set boundary |
| wake_ack | input | 1 | Partner acknowledgement that the wake handshake has finished |
| active_mask | output | 16 | Lanes carrying traffic in both directions |
| eios_mask | output | 16 | Lanes that send an electrical-idle ordered set this cycle |
| wake_mask | output | 16 | Lanes running the wake handshake |
| width | output | 5 | Committed lane count |
| busy | output | 1 | A request is pending or a transition is in progress |
| done | output | 1 | One-cycle pulse when a new width is committed |

## Verification
Several kinds of wrong internal state show up directly at the ports:
- A corrupted lane mask or width register shows at once. `width` disagrees with the population count of `active_mask`, or the mask has a gap above lane 0.
- A shrink state machine that skips its wait drops lanes before any skip strobe. This is caught in the cycle the mask changes.
- A wrong removal set appears in `eios_mask` one cycle before the lanes drop.
- A residency counter that expires early raises `wake_mask` too soon after the last shrink.
- A lost pending request leaves the final width wrong once the first transition has committed.

// File: rtl/lwc_pkg.sv
package lwc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_SHRINK_WAIT = 2'd1,
    ST_SHRINK_IDLE = 2'd2,
    ST_GROW        = 2'd3
  } lwc_state_e;

  // true when v is a power of two no larger than limit
  function automatic logic width_is_legal(input int v, input int limit);
    return (v > 0) && (v <= limit) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/lwc_req_slot.sv
module lwc_req_slot #(
  parameter int LANES = 16,
  parameter int WW    = $clog2(LANES) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flit_mode,
  input  logic          req_valid,
  input  logic [WW-1:0] req_width,
  input  logic          take,
  output logic          pend_valid,
  output logic [WW-1:0] pend_width
);
  import lwc_pkg::*;

  logic accept;
  assign accept = req_valid && flit_mode && width_is_legal(int'(req_width), LANES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_width <= '0;
    end else if (accept) begin
      pend_valid <= 1'b1;          // newest request replaces any older one
      pend_width <= req_width;
    end else if (take) begin
      pend_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lwc_residency.sv
module lwc_residency #(
  parameter int RESIDENCY = 32,
  localparam int CW = $clog2(RESIDENCY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (start)       cnt <= CW'(RESIDENCY);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/link_width_ctrl.sv
module link_width_ctrl #(
  parameter int LANES     = 16,
  parameter int RESIDENCY = 32,
  localparam int WW = $clog2(LANES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flit_mode,
  input  logic             req_valid,
  input  logic [WW-1:0]    req_width,
  input  logic             skp_boundary,
  input  logic             wake_ack,
  output logic [LANES-1:0] active_mask,
  output logic [LANES-1:0] eios_mask,
  output logic [LANES-1:0] wake_mask,
  output logic [WW-1:0]    width,
  output logic             busy,
  output logic             done
);
  import lwc_pkg::*;

  function automatic logic [LANES-1:0] low_lanes(input logic [WW-1:0] n);
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  lwc_state_e       state;
  logic [WW-1:0]    target;
  logic             pend_valid;
  logic [WW-1:0]    pend_width;
  logic             take;
  logic             res_expired;
  logic             shrink_commit;
  logic             grow_ok;

  assign grow_ok       = (pend_width <= width) || res_expired;
  assign take          = (state == ST_IDLE) && pend_valid && grow_ok;
  assign shrink_commit = (state == ST_SHRINK_IDLE);

  lwc_req_slot #(.LANES(LANES), .WW(WW)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .flit_mode  (flit_mode),
    .req_valid  (req_valid),
    .req_width  (req_width),
    .take       (take),
    .pend_valid (pend_valid),
    .pend_width (pend_width)
  );

  lwc_residency #(.RESIDENCY(RESIDENCY)) u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (shrink_commit),
    .expired (res_expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      target      <= WW'(LANES);
      width       <= WW'(LANES);
      active_mask <= '1;
      eios_mask   <= '0;
      wake_mask   <= '0;
      done        <= 1'b0;
    end else begin
      done      <= 1'b0;
      eios_mask <= '0;
      unique case (state)
        ST_IDLE: begin
          if (take) begin
            target <= pend_width;
            if (pend_width < width) begin
              state <= ST_SHRINK_WAIT;
            end else if (pend_width > width) begin
              state     <= ST_GROW;
              wake_mask <= low_lanes(pend_width) & ~active_mask;
            end
          end
        end
        ST_SHRINK_WAIT: begin
          if (skp_boundary) begin
            state     <= ST_SHRINK_IDLE;
            eios_mask <= active_mask & ~low_lanes(target);
          end
        end
        ST_SHRINK_IDLE: begin
          state       <= ST_IDLE;
          active_mask <= low_lanes(target);
          width       <= target;
          done        <= 1'b1;
        end
        ST_GROW: begin
          if (wake_ack) begin
            state       <= ST_IDLE;
            active_mask <= low_lanes(target);
            width       <= target;
            wake_mask   <= '0;
            done        <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE) || pend_valid;
endmodule

// File: rtl/lwc_checker.sv
module lwc_checker #(
  parameter int LANES     = 16,
  parameter int RESIDENCY = 32,
  parameter int WW        = $clog2(LANES) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             skp_boundary,
  input logic             wake_ack,
  input logic [LANES-1:0] active_mask,
  input logic [LANES-1:0] eios_mask,
  input logic [LANES-1:0] wake_mask,
  input logic [WW-1:0]    width,
  input logic             done
);
  localparam int SW = $clog2(RESIDENCY + 2) + 1;
  logic [SW-1:0] since_drop;

  always_ff @(posedge clk) begin
    if (!rst_n)                             since_drop <= SW'(RESIDENCY + 1);
    else if (eios_mask != '0)               since_drop <= '0;
    else if (since_drop < SW'(RESIDENCY + 1)) since_drop <= since_drop + 1'b1;
  end

  // R5
  lanes_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_mask != '0);

  // R4
  mask_contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((active_mask + {{(LANES-1){1'b0}}, 1'b1}) & active_mask) == '0);

  // R4
  width_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(active_mask) == int'(width));

  // R6
  eios_after_skp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eios_mask != '0) |-> $past(skp_boundary));

  // R7
  eios_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eios_mask != '0) |=> (active_mask == ($past(active_mask) & ~$past(eios_mask))));

  // R8
  wake_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_mask & active_mask) == '0);

  // R8
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wake_mask != '0) && !wake_ack) |=> ($stable(active_mask) && $stable(wake_mask)));

  // R9
  residency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|wake_mask) |-> (int'(since_drop) >= RESIDENCY));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind link_width_ctrl lwc_checker #(.LANES(LANES), .RESIDENCY(RESIDENCY), .WW(WW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .skp_boundary (skp_boundary),
  .wake_ack     (wake_ack),
  .active_mask  (active_mask),
  .eios_mask    (eios_mask),
  .wake_mask    (wake_mask),
  .width        (width),
  .done         (done)
);

// File: tb/link_width_ctrl_test.sv
`timescale 1ns/1ps
module link_width_ctrl_test;
  localparam int LANES = 16;
  localparam int RES   = 8;
  localparam int WW    = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             flit_mode = 1'b1;
  logic             req_valid = 1'b0;
  logic [WW-1:0]    req_width = '0;
  logic             skp_boundary = 1'b0;
  logic             wake_ack = 1'b0;
  logic [LANES-1:0] active_mask, eios_mask, wake_mask;
  logic [WW-1:0]    width;
  logic             busy, done;

  int nchk = 0, nfail = 0, cyc = 0, shrink_cyc = -1000;
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  link_width_ctrl #(.LANES(LANES), .RESIDENCY(RES)) uut (
    .clk(clk), .rst_n(rst_n), .flit_mode(flit_mode), .req_valid(req_valid),
    .req_width(req_width), .skp_boundary(skp_boundary), .wake_ack(wake_ack),
    .active_mask(active_mask), .eios_mask(eios_mask), .wake_mask(wake_mask),
    .width(width), .busy(busy), .done(done));

  function automatic int lmask(input int n);
    return (1 << n) - 1;
  endfunction

  function automatic bit legal(input int v);
    return v == 1 || v == 2 || v == 4 || v == 8 || v == 16;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_req(input int w);
    @(negedge clk);
    req_valid = 1'b1;
    req_width = WW'(w);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic change_to(input int to);
    int cur;
    int n;
    cur = int'(width);
    send_req(to);
    if (to == cur) begin
      repeat (3) @(negedge clk);
      chk("R12 width kept", int'(width), cur);
      chk("R12 busy low", int'(busy), 0);
    end else if (to < cur) begin
      @(negedge clk);
      repeat (3) @(negedge clk);
      chk("R6 mask held before skip", int'(active_mask), lmask(cur));
      chk("R6 no eios before skip", int'(eios_mask), 0);
      chk("R11 busy during shrink", int'(busy), 1);
      skp_boundary = 1'b1;
      @(negedge clk);
      skp_boundary = 1'b0;
      chk("R7 eios lanes", int'(eios_mask), lmask(cur) & ~lmask(to));
      chk("R7 lanes still active", int'(active_mask), lmask(cur));
      @(negedge clk);
      chk("R7 mask after drop", int'(active_mask), lmask(to));
      chk("R4 width after drop", int'(width), to);
      chk("R11 done on shrink", int'(done), 1);
      chk("R7 eios one cycle", int'(eios_mask), 0);
      shrink_cyc = cyc;
    end else begin
      n = 0;
      @(negedge clk);
      while (wake_mask == '0 && n < RES + 20) begin
        @(negedge clk);
        n++;
      end
      chk("R8 wake lanes", int'(wake_mask), lmask(to) & ~lmask(cur));
      chk("R9 residency respected", int'((cyc - shrink_cyc) >= RES), 1);
      chk("R8 mask before ack", int'(active_mask), lmask(cur));
      repeat (2) @(negedge clk);
      chk("R8 wake held", int'(wake_mask), lmask(to) & ~lmask(cur));
      wake_ack = 1'b1;
      @(negedge clk);
      wake_ack = 1'b0;
      chk("R8 mask after merge", int'(active_mask), lmask(to));
      chk("R4 width after merge", int'(width), to);
      chk("R11 done on grow", int'(done), 1);
      chk("R8 wake cleared", int'(wake_mask), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 width", int'(width), 16);
    chk("R1 mask", int'(active_mask), 16'hFFFF);
    chk("R1 eios", int'(eios_mask), 0);
    chk("R1 wake", int'(wake_mask), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);

    // R2: every non-legal code is dropped
    for (int w = 0; w < 32; w++) begin
      if (!legal(w)) begin
        send_req(w);
        repeat (2) @(negedge clk);
        chk("R2 width kept", int'(width), 16);
        chk("R2 busy low", int'(busy), 0);
      end
    end

    // R3: flit mode off
    flit_mode = 1'b0;
    send_req(2);
    repeat (6) @(negedge clk);
    chk("R3 width kept", int'(width), 16);
    chk("R3 mask kept", int'(active_mask), 16'hFFFF);
    flit_mode = 1'b1;

    // sweep all legal from/to pairs
    for (int a = 0; a < 5; a++) begin
      for (int b = 0; b < 5; b++) begin
        change_to(1 << a);
        change_to(1 << b);
      end
    end

    // R10: request arriving mid-shrink is held, newest wins
    change_to(16);
    send_req(4);
    @(negedge clk);
    send_req(8);
    send_req(2);
    chk("R10 width during hold", int'(width), 16);
    skp_boundary = 1'b1;
    @(negedge clk);
    skp_boundary = 1'b0;
    chk("R10 first eios", int'(eios_mask), 16'hFFF0);
    @(negedge clk);
    chk("R10 first commit", int'(width), 4);
    chk("R10 busy with held request", int'(busy), 1);
    @(negedge clk);
    skp_boundary = 1'b1;
    @(negedge clk);
    skp_boundary = 1'b0;
    chk("R10 second eios", int'(eios_mask), 16'h000C);
    @(negedge clk);
    chk("R10 second commit", int'(width), 2);
    repeat (2) @(negedge clk);
    chk("R11 busy cleared", int'(busy), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule